// File: doc/BRIEF.md
# Overwriting FIFO with Fractional Occupancy Flags

This block is a single-clock circular buffer controller built around a small memory array. A write port stores one sample per enabled cycle at the write pointer. A read port returns one sample per enabled cycle from the read pointer. Each port can also force its pointer to zero (clear) or to an address it supplies (set).

The buffer never refuses a write. When every location holds unread data, a new write replaces the oldest sample, and the read side moves past the sample it lost. When the buffer has nothing left to read, the read pointer stays where it is and each read returns the most recently written sample again. Reading never removes data, so a location can be read again after a set command.

Occupancy is reported through a pointer-equality flag and two threshold flags. Each threshold is chosen by a fraction input in steps of one eightieth of the depth. Issuing any pointer command while the load qualifier is high switches the block into free-running mode, in which reads always advance. After that switch the occupancy flags are marked as no longer trustworthy.

Top module: `ofifo_overwrite`

## Requirements
- R1: With no commands, each enabled write stores wr_data_i and advances the write pointer, and each enabled read returns stored samples in write order; both pointers wrap from DEPTH-1 to 0.
- R2: A write-only cycle on a buffer holding DEPTH unread samples overwrites the oldest one; the following DEPTH reads return the most recent DEPTH samples in order.
- R3: Until free-running mode starts, a read on an empty buffer leaves the read pointer unchanged and returns the last written sample; a later write then makes that new sample the next read result.
- R4: collide_o is high exactly when the read and write pointers are equal, including right after reset and after clearing both pointers.
- R5: almost_empty_o is high when the unread count is below floor(DEPTH*ae_k_i/80).
- R6: almost_full_o is high when DEPTH minus the unread count is below floor(DEPTH*af_k_i/80); a full buffer counts DEPTH unread samples.
- R7: A clear sets its pointer to 0 and a set loads its pointer from that port's set address (values above DEPTH-1 taken as DEPTH-1); clear wins over set in the same cycle, a command replaces that port's increment, and any command empties the full state.
- R8: Any pointer command issued while load_i is high starts free-running mode: flag_valid_o drops and stays low until reset, and from then on every enabled read advances the read pointer even when the pointers are equal.
- R9: rd_data_o changes only on cycles with rd_en_i high, and setting the read pointer back to an earlier location returns the same data again.
- R10: After reset, rd_data_o is 0, collide_o is 1, almost_empty_o follows R5 with an empty buffer, almost_full_o is 0 for af_k_i up to 79, and flag_valid_o is 1; every memory location reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | WIDTH | Write data |
| wr_clr_i | input | 1 | Force write pointer to 0 |
| wr_set_i | input | 1 | Load write pointer from wr_set_addr_i |
| wr_set_addr_i | input | AW | Write pointer set address |
| rd_en_i | input | 1 | Read enable |
| rd_clr_i | input | 1 | Force read pointer to 0 |
| rd_set_i | input | 1 | Load read pointer from rd_set_addr_i |
| rd_set_addr_i | input | AW | Read pointer set address |
| load_i | input | 1 | Qualifier that makes a pointer command start free-running mode |
| ae_k_i | input | KW | Almost-empty threshold in eightieths of DEPTH |
| af_k_i | input | KW | Almost-full threshold in eightieths of DEPTH |
| rd_data_o | output | WIDTH | Registered read data |
| collide_o | output | 1 | Read and write pointers are equal |
| almost_empty_o | output | 1 | Unread count below the empty threshold |
| almost_full_o | output | 1 | Free space below the full threshold |
| flag_valid_o | output | 1 | Occupancy flags are meaningful (low in free-running mode) |

## Verification
rd_data_o is registered, so a read's result shows up at the first rising edge after the cycle in which rd_en_i is high. The three flags are built without registers from the pointer and full-state registers, and flag_valid_o comes straight from its own register, so a command or enable affects them at that same edge. The threshold inputs act on the flags within the same cycle. The bench drives every input at the falling edge. It samples all outputs one nanosecond after the next rising edge, compares them against a model updated once per edge, and checks the reset state before the first edge.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;
  localparam int unsigned FRAC_STEPS = 80;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC  = 2'd1,
    PC_SET  = 2'd2,
    PC_CLR  = 2'd3
  } ptr_cmd_e;

  function automatic ptr_cmd_e ptr_cmd(input logic clr, input logic set, input logic inc);
    if (clr)      return PC_CLR;
    else if (set) return PC_SET;
    else if (inc) return PC_INC;
    else          return PC_HOLD;
  endfunction
endpackage

// File: rtl/ofifo_ptr.sv
module ofifo_ptr
  import ofifo_pkg::*;
#(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned AW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ptr_cmd_e      cmd_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] prv_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign nxt_o = (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  assign prv_o = (ptr_o == '0) ? LAST : ptr_o - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else begin
      unique case (cmd_i)
        PC_CLR:  ptr_o <= '0;
        PC_SET:  ptr_o <= (addr_i > LAST) ? LAST : addr_i;
        PC_INC:  ptr_o <= nxt_o;
        default: ptr_o <= ptr_o;
      endcase
    end
  end
endmodule

// File: rtl/ofifo_mem.sv
module ofifo_mem #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read-before-write on the same address
  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/ofifo_flags.sv
module ofifo_flags
  import ofifo_pkg::*;
#(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned AW    = 7,
  parameter int unsigned KW    = 7
) (
  input  logic [AW-1:0] wptr_i,
  input  logic [AW-1:0] rptr_i,
  input  logic          full_i,
  input  logic [KW-1:0] ae_k_i,
  input  logic [KW-1:0] af_k_i,
  output logic          ae_o,
  output logic          af_o
);
  localparam int unsigned PW = $clog2(DEPTH + 1) + KW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] STEPS_P = PW'(FRAC_STEPS);

  logic [PW-1:0] w_p, r_p, fill, room;
  logic [KW-1:0] k   [2];
  logic [PW-1:0] thr [2];

  assign k[0] = ae_k_i;
  assign k[1] = af_k_i;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    assign thr[g] = (DEPTH_P * {{(PW-KW){1'b0}}, k[g]}) / STEPS_P;
  end

  assign w_p  = {{(PW-AW){1'b0}}, wptr_i};
  assign r_p  = {{(PW-AW){1'b0}}, rptr_i};
  assign fill = full_i ? DEPTH_P : (w_p >= r_p) ? (w_p - r_p) : (w_p + DEPTH_P - r_p);
  assign room = DEPTH_P - fill;

  assign ae_o = fill < thr[0];
  assign af_o = room < thr[1];
endmodule

// File: rtl/ofifo_overwrite.sv
module ofifo_overwrite
  import ofifo_pkg::*;
#(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned KW    = 7,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wr_clr_i,
  input  logic             wr_set_i,
  input  logic [AW-1:0]    wr_set_addr_i,
  input  logic             rd_en_i,
  input  logic             rd_clr_i,
  input  logic             rd_set_i,
  input  logic [AW-1:0]    rd_set_addr_i,
  input  logic             load_i,
  input  logic [KW-1:0]    ae_k_i,
  input  logic [KW-1:0]    af_k_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             collide_o,
  output logic             almost_empty_o,
  output logic             almost_full_o,
  output logic             flag_valid_o
);
  logic [AW-1:0]    wptr, rptr, w_nxt, w_prv, r_nxt, r_prv;
  logic [WIDTH-1:0] mem_rd, mem_last;
  logic             full_q, free_q;
  logic             wr_cmd, rd_cmd, ptr_eq, empty, halt, rd_adv, push_old;
  ptr_cmd_e         wcmd, rcmd;

  assign wr_cmd   = wr_clr_i | wr_set_i;
  assign rd_cmd   = rd_clr_i | rd_set_i;
  assign ptr_eq   = (wptr == rptr);
  assign empty    = ptr_eq & ~full_q;
  assign halt     = ~free_q & empty;
  assign rd_adv   = rd_en_i & ~halt & ~rd_cmd;
  // full and write-only: drop the oldest sample
  assign push_old = full_q & wr_en_i & ~rd_en_i & ~wr_cmd & ~rd_cmd;

  assign wcmd = ptr_cmd(wr_clr_i, wr_set_i, wr_en_i);
  assign rcmd = ptr_cmd(rd_clr_i, rd_set_i, rd_adv | push_old);

  ofifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i, .rst_ni, .cmd_i(wcmd), .addr_i(wr_set_addr_i),
    .ptr_o(wptr), .nxt_o(w_nxt), .prv_o(w_prv)
  );

  ofifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i, .rst_ni, .cmd_i(rcmd), .addr_i(rd_set_addr_i),
    .ptr_o(rptr), .nxt_o(r_nxt), .prv_o(r_prv)
  );

  ofifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .we_i(wr_en_i), .waddr_i(wptr), .wdata_i(wr_data_i),
    .raddr_a_i(rptr), .rdata_a_o(mem_rd),
    .raddr_b_i(w_prv), .rdata_b_o(mem_last)
  );

  ofifo_flags #(.DEPTH(DEPTH), .AW(AW), .KW(KW)) u_flags (
    .wptr_i(wptr), .rptr_i(rptr), .full_i(full_q),
    .ae_k_i, .af_k_i, .ae_o(almost_empty_o), .af_o(almost_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else if (wr_cmd | rd_cmd) begin
      full_q <= 1'b0;
    end else if (wr_en_i & ~rd_adv) begin
      full_q <= full_q | (w_nxt == rptr);
    end else if (rd_adv & ~wr_en_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           free_q <= 1'b0;
    else if (load_i & (wr_cmd | rd_cmd))   free_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= halt ? mem_last : mem_rd;
  end

  assign collide_o    = ptr_eq;
  assign flag_valid_o = ~free_q;

  logic unused_r;
  assign unused_r = ^{r_nxt, r_prv};
endmodule

// File: rtl/ofifo_chk.sv
module ofifo_chk #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned KW    = 7,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             wr_clr_i,
  input logic             wr_set_i,
  input logic [AW-1:0]    wr_set_addr_i,
  input logic             rd_en_i,
  input logic             rd_clr_i,
  input logic             rd_set_i,
  input logic [AW-1:0]    rd_set_addr_i,
  input logic             load_i,
  input logic [KW-1:0]    ae_k_i,
  input logic [KW-1:0]    af_k_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             collide_o,
  input logic             almost_empty_o,
  input logic             almost_full_o,
  input logic             flag_valid_o
);
  logic no_cmd, k_ok;
  assign no_cmd = !wr_clr_i && !wr_set_i && !rd_clr_i && !rd_set_i;
  assign k_ok   = (ae_k_i != '0) && (ae_k_i <= KW'(79));

  assert_clr_collide_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i && rd_clr_i |=> collide_o);

  assert_empty_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o && collide_o && almost_empty_o && k_ok && rd_en_i && !wr_en_i && no_cmd
    |=> collide_o);

  assert_overwrite_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_valid_o && collide_o && !almost_empty_o && k_ok && wr_en_i && !rd_en_i && no_cmd
    |=> collide_o);

  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_valid_o |=> !flag_valid_o);

  assert_valid_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_valid_o) |-> $past(load_i && (wr_clr_i || wr_set_i || rd_clr_i || rd_set_i)));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  logic unused_c;
  assign unused_c = ^{wr_data_i, wr_set_addr_i, rd_set_addr_i, af_k_i, almost_full_o};
endmodule

bind ofifo_overwrite ofifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .KW(KW)) u_chk (.*);

// File: tb/tb_ofifo_overwrite.sv
`timescale 1ns/1ps
module tb_ofifo_overwrite;
  localparam int D  = 80;
  localparam int W  = 8;
  localparam int KW = 7;
  localparam int AW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, wc = 0, ws = 0, re = 0, rc = 0, rs = 0, ld = 0;
  logic [W-1:0]  wd = '0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [KW-1:0] aek = 7'd1, afk = 7'd1;
  logic [W-1:0]  rdata;
  logic collide, ae, af, fv;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m [D];
  int wp = 0, rp = 0, mrd = 0;
  bit full = 0, free = 0;

  always #2.5 clk = ~clk;

  ofifo_overwrite #(.DEPTH(D), .WIDTH(W), .KW(KW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(we), .wr_data_i(wd), .wr_clr_i(wc), .wr_set_i(ws), .wr_set_addr_i(wa),
    .rd_en_i(re), .rd_clr_i(rc), .rd_set_i(rs), .rd_set_addr_i(ra),
    .load_i(ld), .ae_k_i(aek), .af_k_i(afk),
    .rd_data_o(rdata), .collide_o(collide), .almost_empty_o(ae),
    .almost_full_o(af), .flag_valid_o(fv)
  );

  task automatic chk(input string tg, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tg, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tg);
    int fill;
    fill = full ? D : (wp - rp + D) % D;
    chk({tg, " rd_data"}, int'(rdata), mrd);
    chk("R4 collide", int'(collide), int'(wp == rp));
    chk("R5 almost_empty", int'(ae), int'(fill < (D * int'(aek)) / 80));
    chk("R6 almost_full", int'(af), int'((D - fill) < (D * int'(afk)) / 80));
    chk("R8 flag_valid", int'(fv), int'(!free));
  endtask

  // apply one cycle of stimulus at the falling edge, check after the rising edge
  task automatic step(input string tg, input bit i_we, input int i_wd, input bit i_wc,
                      input bit i_ws, input int i_wa, input bit i_re, input bit i_rc,
                      input bit i_rs, input int i_ra, input bit i_ld);
    bit empty, halt, rdadv, cw, cr;
    int wnx;
    we = i_we; wd = W'(i_wd); wc = i_wc; ws = i_ws; wa = AW'(i_wa);
    re = i_re; rc = i_rc; rs = i_rs; ra = AW'(i_ra); ld = i_ld;
    cw = i_wc | i_ws; cr = i_rc | i_rs;
    empty = (wp == rp) && !full;
    halt  = !free && empty;
    rdadv = i_re && !halt && !cr;
    if (i_re) mrd = halt ? m[(wp + D - 1) % D] : m[rp];
    wnx = (wp + 1) % D;
    if (cw || cr)             full = 0;
    else if (i_we && !rdadv)  full = full || (wnx == rp);
    else if (rdadv && !i_we)  full = 0;
    if (i_rc)       rp = 0;
    else if (i_rs)  rp = (i_ra > D - 1) ? D - 1 : i_ra;
    else if (rdadv || (!i_re && i_we && !cw && (wp == rp) && !empty)) rp = (rp + 1) % D;
    if (i_we) m[wp] = i_wd & 255;
    if (i_wc)       wp = 0;
    else if (i_ws)  wp = (i_wa > D - 1) ? D - 1 : i_wa;
    else if (i_we)  wp = wnx;
    if (i_ld && (cw || cr)) free = 1;
    @(posedge clk);
    #1;
    check_all(tg);
    @(negedge clk);
    we = 0; wc = 0; ws = 0; re = 0; rc = 0; rs = 0; ld = 0;
  endtask

  task automatic wr(input string tg, input int d);
    step(tg, 1, d, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(input string tg);
    step(tg, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) m[i] = 0;
    #12;
    // R10 reset state before any edge after release
    check_all("R10");
    chk("R10 af reset", int'(af), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10");

    // R1 R2 R3 R5 R6: sweep every threshold, fill past full, drain past empty
    for (int k = 1; k <= 79; k++) begin
      aek = KW'(k); afk = KW'(80 - k);
      step("R7", 0, 0, 1, 0, 0, 0, 1, 0, 0, 0);
      for (int i = 0; i < D + (k % 7); i++) wr("R1", k * 3 + i);
      for (int i = 0; i < D; i++) rd((k % 7 != 0) ? "R2" : "R1");
      rd("R3");
      rd("R3");
      wr("R3", k + 100);
      rd("R3");
    end

    // R7: clear beats set, set loads address, clamps above DEPTH-1
    aek = 7'd10; afk = 7'd10;
    step("R7", 0, 0, 1, 1, 33, 0, 1, 1, 40, 0);
    step("R7", 0, 0, 0, 1, 5, 0, 0, 1, 5, 0);
    for (int i = 0; i < 4; i++) wr("R7", 200 + i);
    step("R7", 0, 0, 0, 1, 127, 0, 0, 1, 127, 0);
    step("R7", 1, 55, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 0, 1, 5, 0);

    // R9: re-read after set, hold without enable
    for (int pass = 0; pass < 2; pass++) begin
      step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 5, 0);
      for (int i = 0; i < 4; i++) rd("R9");
      for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end

    // R8: load with command leaves halt mode, reads run past the writer
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    step("R8", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) wr("R8", 90 + i);
    for (int i = 0; i < 6; i++) rd("R8");
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) rd("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule